// File: doc/BRIEF.md
# Infrared Receive Edge Capture Timer

This block measures the time between transitions on an infrared receive line so that software can demodulate pulse-width coded frames. The receive input is first resynchronised to the block clock. Its transitions are then qualified against a configurable edge selection. A free-running interval counter is restarted by every qualified transition. The counter advances either on carrier-period ticks or on ticks of the finer IR base clock. Both tick strobes come from outside the block.

The first qualified transition after the block becomes active only arms the counter. Each later one copies the elapsed count into a capture register, records the line level that the transition produced, and sets a sticky flag. An interrupt request follows the flag when interrupts are enabled. Software clears the flag with a write-one-to-clear strobe. The block is active only while it is enabled and the mode input selects receive. Leaving that state disarms the counter.

Top module: `ir_rx_capture`

## Requirements
- R1: After reset, `cap_count` is 0, `rx_level` is 0, `cap_flag` is 0 and `irq` is 0.
- R2: Qualified events occur only while `cfg_en` = 1 and `cfg_tx_mode` = 0. In any other setting no capture occurs and the counter is disarmed, so the first event after reactivation only arms it.
- R3: Edge selection on `cfg_edge_sel` works as follows:
  - bit 0 = 1 qualifies falling transitions;
  - bit 1 = 1 qualifies rising transitions;
  - 2'b11 qualifies both directions;
  - 2'b00 qualifies none, and capture is disabled.
- R4: The first qualified event after arming is lost clears the counter to 0 and arms it. It changes neither `cap_count` nor `cap_flag`.
- R5: Each later qualified event loads the current count into `cap_count` and restarts the counter at 0. The result is visible three clock cycles after the input change: two synchroniser stages plus one capture register.
- R6: With `cfg_fine_clk` = 0, the armed counter advances once per cycle in which `carrier_tick` = 1, and `base_tick` has no effect.
- R7: With `cfg_fine_clk` = 1, the armed counter advances once per cycle in which `base_tick` = 1, and `carrier_tick` has no effect.
- R8: On each capture, `rx_level` takes the line level after the transition: 1 after a rising edge and 0 after a falling edge.
- R9: A capture sets `cap_flag`, which stays set until a cycle with `flag_clr` = 1 clears it. A capture in the same cycle as the clear wins.
- R10: `irq` is 1 exactly when `cap_flag` = 1 and `cfg_irq_en` = 1.
- R11: The counter stops at 16'hFFFF instead of wrapping, so an over-long interval captures as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Timer enable |
| cfg_tx_mode | input | 1 | 1 = transmit mode (block idle), 0 = receive |
| cfg_edge_sel | input | 2 | Qualifying edges: bit 0 falling, bit 1 rising |
| cfg_fine_clk | input | 1 | 0 = count carrier ticks, 1 = count base-clock ticks |
| cfg_irq_en | input | 1 | Interrupt enable |
| carrier_tick | input | 1 | One-cycle strobe per carrier period |
| base_tick | input | 1 | One-cycle strobe per IR base clock |
| rx_in | input | 1 | Asynchronous infrared receive line |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| cap_count | output | 16 | Interval captured at the last event |
| rx_level | output | 1 | Line level recorded at the last capture |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A change on `rx_in` becomes a qualified event in the cycle after its second synchroniser edge. The capture register, level bit and flag update on the third rising edge after the input change. `irq` and flag clearing follow in the same cycle as the flag and one edge after the clear strobe, respectively.

The bench drives every input on a falling edge and counts rising edges explicitly between stimuli. For base-clock counting, two line changes spaced G edges apart capture G-1. For carrier counting, a known number of single-cycle ticks is placed strictly between two events so that the expected count equals that number. All outputs are sampled on the falling edge after the due rising edge.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;
  // edge selection bits
  localparam int unsigned SEL_FALL_BIT = 0;
  localparam int unsigned SEL_RISE_BIT = 1;
endpackage

// File: rtl/ir_rx_sync_edge.sv
module ir_rx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = din;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  assign prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/ir_rx_interval_cnt.sv
module ir_rx_interval_cnt
  import ir_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic evt,
  input  logic tick,
  output cnt_t cnt,
  output logic armed
);
  localparam cnt_t CNT_MAX = '1;

  cnt_t cnt_q, cnt_d;
  logic armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!active) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (evt) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (armed_q && tick && (cnt_q != CNT_MAX)) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt   = cnt_q;
  assign armed = armed_q;
endmodule

// File: rtl/ir_rx_capture_regs.sv
module ir_rx_capture_regs
  import ir_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  cnt_t cnt,
  input  logic level,
  input  logic flag_clr,
  output cnt_t cap_q,
  output logic lvl_q,
  output logic flag_q
);
  cnt_t cap_d;
  logic lvl_d, flag_d, cap_en;

  assign cap_en = capture;

  always_comb begin
    cap_d  = cap_q;
    lvl_d  = lvl_q;
    flag_d = flag_q & ~flag_clr;
    if (cap_en) begin
      cap_d  = cnt;
      lvl_d  = level;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/ir_rx_capture.sv
module ir_rx_capture
  import ir_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        cfg_tx_mode,
  input  logic [1:0]  cfg_edge_sel,
  input  logic        cfg_fine_clk,
  input  logic        cfg_irq_en,
  input  logic        carrier_tick,
  input  logic        base_tick,
  input  logic        rx_in,
  input  logic        flag_clr,
  output logic [15:0] cap_count,
  output logic        rx_level,
  output logic        cap_flag,
  output logic        irq
);
  logic rx_lvl, rx_rise, rx_fall;
  logic active, qual_evt, sel_tick, armed_w, capture;
  cnt_t cnt_w, cap_w;
  logic lvl_w, flag_w;

  ir_rx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_in),
    .level (rx_lvl),
    .rise  (rx_rise),
    .fall  (rx_fall)
  );

  assign active   = cfg_en & ~cfg_tx_mode;
  assign qual_evt = active & ((cfg_edge_sel[SEL_FALL_BIT] & rx_fall) |
                              (cfg_edge_sel[SEL_RISE_BIT] & rx_rise));
  assign sel_tick = cfg_fine_clk ? base_tick : carrier_tick;

  ir_rx_interval_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .evt    (qual_evt),
    .tick   (sel_tick),
    .cnt    (cnt_w),
    .armed  (armed_w)
  );

  assign capture = qual_evt & armed_w;

  ir_rx_capture_regs u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .cnt      (cnt_w),
    .level    (rx_lvl),
    .flag_clr (flag_clr),
    .cap_q    (cap_w),
    .lvl_q    (lvl_w),
    .flag_q   (flag_w)
  );

  assign cap_count = cap_w;
  assign rx_level  = lvl_w;
  assign cap_flag  = flag_w;
  assign irq       = flag_w & cfg_irq_en;
endmodule

// File: rtl/ir_rx_capture_chk.sv
module ir_rx_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        cfg_tx_mode,
  input logic [1:0]  cfg_edge_sel,
  input logic        cfg_irq_en,
  input logic        flag_clr,
  input logic [15:0] cap_count,
  input logic        rx_level,
  input logic        cap_flag,
  input logic        irq,
  input logic [15:0] cnt,
  input logic        armed,
  input logic        evt
);
  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && !cfg_tx_mode) |=> $stable(cap_count)); // R2
  AST_SEL_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_edge_sel == 2'b00) |=> ($stable(cap_count) && $stable(rx_level))); // R3
  AST_FIRST_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cap_flag) |=> !cap_flag); // R4
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && evt) |=> (cnt == 16'h0000)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(armed && evt)) |=> !cap_flag); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq); // R10
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !evt && cfg_en && !cfg_tx_mode) |=> (cnt == 16'hFFFF)); // R11
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !evt && cfg_en && !cfg_tx_mode) |=> (cnt >= $past(cnt))); // R11
endmodule

bind ir_rx_capture ir_rx_capture_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_tx_mode  (cfg_tx_mode),
  .cfg_edge_sel (cfg_edge_sel),
  .cfg_irq_en   (cfg_irq_en),
  .flag_clr     (flag_clr),
  .cap_count    (cap_count),
  .rx_level     (rx_level),
  .cap_flag     (cap_flag),
  .irq          (irq),
  .cnt          (cnt_w),
  .armed        (armed_w),
  .evt          (qual_evt)
);

// File: tb/ir_rx_capture_tb_top.sv
module ir_rx_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_tx_mode, cfg_fine_clk, cfg_irq_en;
  logic [1:0]  cfg_edge_sel;
  logic        carrier_tick, base_tick, rx_in, flag_clr;
  logic [15:0] cap_count;
  logic        rx_level, cap_flag, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  ir_rx_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx_mode(cfg_tx_mode),
    .cfg_edge_sel(cfg_edge_sel), .cfg_fine_clk(cfg_fine_clk),
    .cfg_irq_en(cfg_irq_en), .carrier_tick(carrier_tick), .base_tick(base_tick),
    .rx_in(rx_in), .flag_clr(flag_clr), .cap_count(cap_count),
    .rx_level(rx_level), .cap_flag(cap_flag), .irq(irq)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fine, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; rx_in = 1'b0; flag_clr = 1'b0;
    cfg_en = 1'b1; cfg_tx_mode = 1'b0; cfg_edge_sel = sel;
    cfg_fine_clk = fine; cfg_irq_en = 1'b0;
    carrier_tick = 1'b0; base_tick = fine;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_rx(input logic v);
    @(negedge clk);
    rx_in = v;
  endtask

  // drive a level, then sample after the three edges a result needs
  task automatic step_rx(input logic v);
    set_rx(v);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 2'b11);
    chk("R1", "cap_count", cap_count, 0);
    chk("R1", "rx_level", rx_level, 0);
    chk("R1", "cap_flag", cap_flag, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_fine_both();
    do_reset(1'b1, 2'b11);
    step_rx(1'b1);
    chk("R4", "flag after arming event", cap_flag, 0);
    chk("R4", "cap after arming event", cap_count, 0);
    repeat (20 - 3) @(posedge clk);
    step_rx(1'b0);
    chk("R5", "fine interval 20", cap_count, 19);
    chk("R8", "level after falling", rx_level, 0);
    chk("R9", "flag set on capture", cap_flag, 1);
    repeat (7 - 3) @(posedge clk);
    step_rx(1'b1);
    chk("R7", "fine interval 7", cap_count, 6);
    chk("R8", "level after rising", rx_level, 1);
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk("R10", "irq with enable", irq, 1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    chk("R10", "irq masked", irq, 0);
    chk("R9", "flag sticky", cap_flag, 1);
    cfg_irq_en = 1'b1;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9", "flag cleared", cap_flag, 0);
    chk("R10", "irq follows clear", irq, 0);
    cfg_irq_en = 1'b0;
  endtask

  task automatic t_carrier();
    do_reset(1'b0, 2'b11);
    step_rx(1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); carrier_tick = 1'b1;
      @(negedge clk); carrier_tick = 1'b0;
      @(negedge clk);
    end
    step_rx(1'b0);
    chk("R6", "carrier ticks counted, base ignored", cap_count, 5);
  endtask

  task automatic t_fine_ignores_carrier();
    do_reset(1'b1, 2'b11);
    base_tick = 1'b0;
    step_rx(1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); carrier_tick = 1'b1; base_tick = (i < 3);
      @(negedge clk); carrier_tick = 1'b0; base_tick = 1'b0;
    end
    step_rx(1'b0);
    chk("R7", "base ticks counted, carrier ignored", cap_count, 3);
  endtask

  task automatic t_edge_sel();
    do_reset(1'b1, 2'b01);
    step_rx(1'b1);
    step_rx(1'b0);
    chk("R3", "rising ignored, falling arms", cap_flag, 0);
    step_rx(1'b1);
    chk("R3", "rising ignored when falling only", cap_flag, 0);
    step_rx(1'b0);
    chk("R3", "falling-to-falling interval", cap_count, 7);
    chk("R3", "falling-only capture flag", cap_flag, 1);
    do_reset(1'b1, 2'b10);
    step_rx(1'b1);
    step_rx(1'b0);
    step_rx(1'b1);
    chk("R3", "rising-to-rising interval", cap_count, 7);
    chk("R8", "rising-only level", rx_level, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    cfg_edge_sel = 2'b00;
    step_rx(1'b0);
    step_rx(1'b1);
    chk("R3", "code 00 no flag", cap_flag, 0);
    chk("R3", "code 00 cap unchanged", cap_count, 7);
  endtask

  task automatic t_mode();
    do_reset(1'b1, 2'b11);
    cfg_tx_mode = 1'b1;
    step_rx(1'b1);
    step_rx(1'b0);
    chk("R2", "transmit mode no capture", cap_flag, 0);
    cfg_tx_mode = 1'b0;
    step_rx(1'b1);
    chk("R2", "first event after receive only arms", cap_flag, 0);
    step_rx(1'b0);
    chk("R2", "capture in receive mode", cap_count, 3);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    cfg_en = 1'b0;
    step_rx(1'b1);
    step_rx(1'b0);
    chk("R2", "disabled no flag", cap_flag, 0);
    chk("R2", "disabled cap unchanged", cap_count, 3);
    cfg_en = 1'b1;
    step_rx(1'b1);
    chk("R2", "re-enable disarms", cap_flag, 0);
    step_rx(1'b0);
    chk("R2", "capture after re-enable", cap_flag, 1);
  endtask

  task automatic t_saturate();
    do_reset(1'b1, 2'b11);
    step_rx(1'b1);
    repeat (70000) @(posedge clk);
    step_rx(1'b0);
    chk("R11", "saturated interval", cap_count, 16'hFFFF);
    repeat (10 - 3) @(posedge clk);
    step_rx(1'b1);
    chk("R5", "restart after saturation", cap_count, 9);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_fine_both();
    t_carrier();
    t_fine_ignores_carrier();
    t_edge_sel();
    t_mode();
    t_saturate();
    finish_run();
  end
endmodule